// File: doc/BRIEF.md
# Programmable Truth-Table Trigger Evaluator

This block watches a 16-channel logic input and decides, on every clock, whether the input satisfies a trigger condition. The condition is not built from fixed comparators. It lives in small programmable truth tables. The channels form four groups of four. In each stage, every group's four bits select one entry of a 16-entry table, and the stage output is the AND of the four group entries.

There are three such stages: a level stage, used for value/mask matching, and two transition stages. The two transition stages are usually programmed to follow one channel each. A 16-entry glue table sees the current and previous-cycle outputs of both transition stages, so rising and falling edges are written as (previous, current) pairs. A secondary glue table is indexed the same way. A final 16-entry combine table merges the glue results with the level result.

Software loads the tables one bit column at a time through a byte-wide write port. After arming, the block emits a single one-cycle trigger pulse on the first sample that qualifies, and then disarms.

Top module: `lut_trig_eval`

## Requirements
- R1: After reset, `trig` is 0 and the tables hold their defaults. The level, transition and glue tables are all ones and the combine table is 0xA000. With these defaults, the first sample after arming fires.
- R2: The level stage result is the AND, over quads q = 0..3, of level table q at the entry indexed by `din[4q+3:4q]`. A value/mask table clears exactly those entries in which a masked channel differs from its required value.
- R3: The glue index is {stage1 previous, stage1 current, stage0 previous, stage0 current}, with bit 0 = stage0 current. A rising edge is the pattern previous=0, current=1 and a falling edge is previous=1, current=0. The "previous" value is the stage output at the preceding armed sample.
- R4: On the first sample after arming, the previous-cycle values equal the current ones, so no edge can be seen on that sample, whatever earlier samples held.
- R5: A qualifying sample produces a `trig` pulse exactly one cycle wide, visible after the clock edge that samples it. The block then disarms and stays quiet until `arm` is pulsed again.
- R6: Loading protocol. A data write (`cfg_wr`=1, `cfg_sel`=0) stores the first byte and then the second byte. A select write (`cfg_sel`=1) whose data is 0x30|i copies the held bytes into bit column i of every table. Byte 1 is laid out as: bits 3:0 = level quads 0..3, bit 4 = glue, bit 5 = secondary glue, bit 6 = combine. Byte 2 is laid out as: bits 3:0 = stage0 quads 0..3, bits 7:4 = stage1 quads 0..3. Every select write returns the byte pointer to the first byte.
- R7: A select write whose upper nibble is not 3 changes no table.
- R8: The combine table is indexed by {1, glue result, secondary glue result, level result}, with bit 0 = level result. `trig` fires when the addressed entry is 1 while armed.
- R9: While disarmed, `trig` stays 0 whatever the input.
- R10: A column write that commits on a sampling edge affects only later samples. The sample taken at that edge is judged with the old table contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | One-cycle pulse that arms the evaluator |
| din | input | 16 | Logic input channels |
| cfg_wr | input | 1 | Table port write strobe |
| cfg_sel | input | 1 | 1: select command, 0: data byte |
| cfg_data | input | 8 | Data byte or select command |
| trig | output | 1 | One-cycle trigger pulse |

## Verification
Table loading and trigger evaluation can land in the same cycle. A select command may commit a column on the very edge that judges an armed sample. The bench arms the block with a combine table that can never fire, then streams the bytes and the select that enable a match while the input already matches. The scoreboard expects no pulse for the sample taken at the commit edge and a pulse for the next sample. This shows that evaluation reads the tables as they stood before the write.

// File: rtl/lut_trig_pkg.sv
package lut_trig_pkg;
  localparam int NCH  = 16;
  localparam int QW   = 4;
  localparam int NQ   = NCH / QW;
  localparam int TD   = 1 << QW;
  localparam int CW   = $clog2(TD);

  typedef logic [TD-1:0] tbl_t;

  typedef struct packed {
    tbl_t [NQ-1:0] lvl;
    tbl_t [NQ-1:0] tr0;
    tbl_t [NQ-1:0] tr1;
    tbl_t          glue;
    tbl_t          glue2;
    tbl_t          comb;
  } tbl_set_t;

  // Power-up contents: every sample qualifies once armed.
  function automatic tbl_set_t default_tables();
    tbl_set_t r;
    for (int q = 0; q < NQ; q++) begin
      r.lvl[q] = '1;
      r.tr0[q] = '1;
      r.tr1[q] = '1;
    end
    r.glue  = '1;
    r.glue2 = '1;
    r.comb  = 16'hA000;
    return r;
  endfunction

  // Scatter one bit column from the two held bytes into every table.
  function automatic tbl_set_t write_column(input tbl_set_t s, input logic [CW-1:0] col,
                                            input logic [6:0] b0, input logic [7:0] b1);
    tbl_set_t r;
    r = s;
    for (int q = 0; q < NQ; q++) begin
      r.lvl[q][col] = b0[q];
      r.tr0[q][col] = b1[q];
      r.tr1[q][col] = b1[NQ+q];
    end
    r.glue[col]  = b0[4];
    r.glue2[col] = b0[5];
    r.comb[col]  = b0[6];
    return r;
  endfunction

  function automatic logic [3:0] glue_index(input logic p1, input logic c1,
                                            input logic p0, input logic c0);
    return {p1, c1, p0, c0};
  endfunction

  function automatic logic [3:0] comb_index(input logic g, input logic g2, input logic lv);
    return {1'b1, g, g2, lv};
  endfunction
endpackage

// File: rtl/lut_trig_loader.sv
module lut_trig_loader
  import lut_trig_pkg::*;
#(
  parameter logic [3:0] SEL_OP = 4'h3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cfg_wr,
  input  logic     cfg_sel,
  input  logic [7:0] cfg_data,
  output tbl_set_t tbls,
  output logic     byte_cnt
);
  logic [6:0] hold0;
  logic [7:0] hold1;
  logic       sel_ok;

  assign sel_ok = cfg_wr && cfg_sel && (cfg_data[7:4] == SEL_OP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbls     <= default_tables();
      hold0    <= '0;
      hold1    <= '0;
      byte_cnt <= 1'b0;
    end else if (cfg_wr) begin
      if (cfg_sel) begin
        byte_cnt <= 1'b0;
        if (sel_ok) tbls <= write_column(tbls, cfg_data[CW-1:0], hold0, hold1);
      end else begin
        if (byte_cnt) hold1 <= cfg_data;
        else          hold0 <= cfg_data[6:0];
        byte_cnt <= ~byte_cnt;
      end
    end
  end
endmodule

// File: rtl/lut_trig_stage.sv
module lut_trig_stage
  import lut_trig_pkg::*;
(
  input  tbl_t [NQ-1:0]  tabs,
  input  logic [NCH-1:0] din,
  output logic           hit
);
  logic [NQ-1:0] qhit;

  for (genvar q = 0; q < NQ; q++) begin : g_quad
    assign qhit[q] = tabs[q][din[q*QW +: QW]];
  end

  assign hit = &qhit;
endmodule

// File: rtl/lut_trig_eval.sv
module lut_trig_eval
  import lut_trig_pkg::*;
#(
  parameter logic [3:0] SEL_OP = 4'h3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        arm,
  input  logic [15:0] din,
  input  logic        cfg_wr,
  input  logic        cfg_sel,
  input  logic [7:0]  cfg_data,
  output logic        trig
);
  tbl_set_t   tbls;
  logic       byte_cnt;
  logic       lvl_hit, tr0_cur, tr1_cur;
  logic       tr0_prev_q, tr1_prev_q, tr0_prev, tr1_prev;
  logic       armed, primed;
  logic [3:0] g_idx, c_idx;
  logic       glue_hit, glue2_hit, fire;

  lut_trig_loader #(.SEL_OP(SEL_OP)) u_load (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .tbls(tbls), .byte_cnt(byte_cnt)
  );

  lut_trig_stage u_lvl (.tabs(tbls.lvl), .din(din), .hit(lvl_hit));
  lut_trig_stage u_tr0 (.tabs(tbls.tr0), .din(din), .hit(tr0_cur));
  lut_trig_stage u_tr1 (.tabs(tbls.tr1), .din(din), .hit(tr1_cur));

  // Until the first armed sample is taken, previous equals current.
  assign tr0_prev  = primed ? tr0_prev_q : tr0_cur;
  assign tr1_prev  = primed ? tr1_prev_q : tr1_cur;
  assign g_idx     = glue_index(tr1_prev, tr1_cur, tr0_prev, tr0_cur);
  assign glue_hit  = tbls.glue[g_idx];
  assign glue2_hit = tbls.glue2[g_idx];
  assign c_idx     = comb_index(glue_hit, glue2_hit, lvl_hit);
  assign fire      = armed && tbls.comb[c_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      primed     <= 1'b0;
      tr0_prev_q <= 1'b0;
      tr1_prev_q <= 1'b0;
      trig       <= 1'b0;
    end else if (arm) begin
      armed  <= 1'b1;
      primed <= 1'b0;
      trig   <= 1'b0;
    end else if (armed) begin
      tr0_prev_q <= tr0_cur;
      tr1_prev_q <= tr1_cur;
      trig       <= fire;
      primed     <= !fire;
      armed      <= !fire;
    end else begin
      trig <= 1'b0;
    end
  end
endmodule

// File: rtl/lut_trig_chk.sv
module lut_trig_chk
  import lut_trig_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       arm,
  input logic       cfg_wr,
  input logic       cfg_sel,
  input logic [7:0] cfg_data,
  input logic       trig,
  input logic       armed,
  input logic       primed,
  input tbl_set_t   tbls,
  input logic       byte_cnt
);
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig);

  assert_disarm_on_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> !armed);

  assert_fire_needs_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(armed));

  assert_prime_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !primed && !arm) |=> (primed || !armed));

  assert_bad_select_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel && cfg_data[7:4] != 4'h3) |=> $stable(tbls));

  assert_select_resets_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel) |=> (byte_cnt == 1'b0));
endmodule

bind lut_trig_eval lut_trig_chk u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
  .cfg_data(cfg_data), .trig(trig), .armed(armed), .primed(primed),
  .tbls(tbls), .byte_cnt(byte_cnt)
);

// File: tb/tb_lut_trig_eval.sv
`timescale 1ns/1ps
module tb_lut_trig_eval;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        arm = 1'b0;
  logic [15:0] din = '0;
  logic        cfg_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [7:0]  cfg_data = '0;
  logic        trig;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  typedef struct {
    logic  e;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  logic [15:0] bvm[4];
  logic [15:0] bt0[4];
  logic [15:0] bt1[4];
  logic [15:0] bglue, bglue2, bcomb;

  always #2 clk = ~clk;

  lut_trig_eval dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .din(din), .cfg_wr(cfg_wr),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data), .trig(trig)
  );

  // Monitor: compares the pulse produced at each edge with the queued expectation.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      compared++;
      if (trig !== it.e) begin
        mismatched++;
        $display("FAIL %s: trig=%0b expected %0b at %0t", it.tag, trig, it.e, $time);
      end
    end
  end

  task automatic cyc(input logic [15:0] d, input logic a, input logic w, input logic s,
                     input logic [7:0] cd, input logic e, input string tag);
    @(negedge clk);
    din = d; arm = a; cfg_wr = w; cfg_sel = s; cfg_data = cd;
    exp_q.push_back('{e, tag});
  endtask

  task automatic samp(input logic [15:0] d, input logic e, input string tag);
    cyc(d, 1'b0, 1'b0, 1'b0, 8'h00, e, tag);
  endtask

  task automatic do_arm(input logic [15:0] d);
    cyc(d, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, "R9");
  endtask

  task automatic wbyte(input logic [15:0] d, input logic [7:0] b, input logic e, input string tag);
    cyc(d, 1'b0, 1'b1, 1'b0, b, e, tag);
  endtask

  task automatic wsel(input logic [15:0] d, input logic [7:0] b, input logic e, input string tag);
    cyc(d, 1'b0, 1'b1, 1'b1, b, e, tag);
  endtask

  task automatic all_ones();
    for (int q = 0; q < 4; q++) begin
      bvm[q] = '1; bt0[q] = '1; bt1[q] = '1;
    end
    bglue = '1; bglue2 = '1; bcomb = 16'hA000;
  endtask

  // Level tables from value/mask: entry kept only when masked bits agree.
  task automatic set_vm(input logic [15:0] val, input logic [15:0] msk);
    for (int q = 0; q < 4; q++)
      for (int idx = 0; idx < 16; idx++)
        bvm[q][idx] = ((4'(idx) ^ val[q*4 +: 4]) & msk[q*4 +: 4]) == 4'h0;
  endtask

  // Transition stage follows one channel.
  task automatic set_tr(input int which, input int ch);
    for (int q = 0; q < 4; q++)
      for (int idx = 0; idx < 16; idx++) begin
        logic v;
        v = (q == ch / 4) ? idx[ch % 4] : 1'b1;
        if (which == 0) bt0[q][idx] = v; else bt1[q][idx] = v;
      end
  endtask

  task automatic load_all();
    for (int i = 0; i < 16; i++) begin
      logic [7:0] b0, b1;
      b0 = {1'b0, bcomb[i], bglue2[i], bglue[i], bvm[3][i], bvm[2][i], bvm[1][i], bvm[0][i]};
      b1 = {bt1[3][i], bt1[2][i], bt1[1][i], bt1[0][i], bt0[3][i], bt0[2][i], bt0[1][i], bt0[0][i]};
      wbyte(16'h0, b0, 1'b0, "R6");
      wbyte(16'h0, b1, 1'b0, "R6");
      wsel(16'h0, 8'h30 | 8'(i), 1'b0, "R6");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compared++;
    if (trig !== 1'b0) begin
      mismatched++;
      $display("FAIL R1: trig=%0b expected 0 in reset", trig);
    end
    rst_n = 1'b1;

    // R1 / R9: defaults, disarmed quiet then first armed sample fires
    samp(16'h1234, 1'b0, "R9");
    samp(16'hFFFF, 1'b0, "R9");
    do_arm(16'h0);
    samp(16'h1234, 1'b1, "R1");
    samp(16'h1234, 1'b0, "R5");
    samp(16'h0000, 1'b0, "R5");

    // R2: value/mask with one quad unmasked
    all_ones();
    set_vm(16'hA5C3, 16'hFF0F);
    load_all();
    do_arm(16'h0);
    samp(16'hA5C2, 1'b0, "R2");
    samp(16'h05C3, 1'b0, "R2");
    samp(16'hA5F3, 1'b1, "R2");
    samp(16'hA5F3, 1'b0, "R5");

    // R3 / R4: rising edge on channel 5 via stage0
    all_ones();
    set_tr(0, 5);
    bglue = 16'h2222;
    load_all();
    samp(16'h0000, 1'b0, "R9");
    samp(16'h0020, 1'b0, "R9");
    do_arm(16'h0000);
    samp(16'h0020, 1'b0, "R4");
    samp(16'h0020, 1'b0, "R3");
    samp(16'h0000, 1'b0, "R3");
    samp(16'h0020, 1'b1, "R3");
    samp(16'h0020, 1'b0, "R5");

    // R3 / R4: falling edge on channel 12 via stage1 (stale previous is 1)
    all_ones();
    set_tr(1, 12);
    bglue = 16'h0F00;
    load_all();
    do_arm(16'h1000);
    samp(16'h0000, 1'b0, "R4");
    samp(16'h1000, 1'b0, "R3");
    samp(16'h0000, 1'b1, "R3");
    samp(16'h0000, 1'b0, "R5");

    // R8: combine index through secondary glue
    all_ones();
    bglue = 16'h0000;
    bcomb = 16'h0800;
    load_all();
    do_arm(16'h0);
    samp(16'h0000, 1'b1, "R8");
    samp(16'h0000, 1'b0, "R5");

    // R7: select with wrong upper nibble leaves column 11 intact
    wbyte(16'h0, 8'h00, 1'b0, "R7");
    wbyte(16'h0, 8'h00, 1'b0, "R7");
    wsel(16'h0, 8'h2B, 1'b0, "R7");
    do_arm(16'h0);
    samp(16'h0000, 1'b1, "R7");

    // R6: proper select clears column 11, so no further trigger
    wbyte(16'h0, 8'h00, 1'b0, "R6");
    wbyte(16'h0, 8'h00, 1'b0, "R6");
    wsel(16'h0, 8'h3B, 1'b0, "R6");
    do_arm(16'h0);
    samp(16'h0000, 1'b0, "R6");
    samp(16'h0000, 1'b0, "R6");
    samp(16'h0000, 1'b0, "R6");

    // R10: column 15 committed while armed; commit-edge sample uses old tables
    wbyte(16'h0, 8'h7F, 1'b0, "R10");
    wbyte(16'h0, 8'hFF, 1'b0, "R10");
    wsel(16'h0, 8'h3F, 1'b0, "R10");
    samp(16'h0000, 1'b1, "R10");
    samp(16'h0000, 1'b0, "R5");

    @(negedge clk);
    arm = 1'b0; cfg_wr = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule